// File: doc/BRIEF.md
# CardBus Function Event Unit

This block keeps the legacy power-management event registers for three card functions on a CardBus card. Each function has four 32-bit registers: an event register, a mask register, a read-only present-state register and a write-only force register. Older host software uses these registers to find and clear wake and interrupt events. Each function's wake bit is the same latch as its PCI power-management status bit. Each function's wake enables follow PCI enable writes, but they never feed back into the PCI enable.

The block drives an active-low power-management event output and an active-high interrupt output. Both outputs are gated by a master mask in each function and by the bus-mode input, which must select CardBus (2'b01). Wake pulses come in per function. A single shared interrupt-detect pulse marks an interrupt as pending in every function. A write to a function's force register raises a wake or interrupt event for that function alone.

Top module: `cb_evt_unit`

## Requirements
- R1: Register offset = function*16 + register*4, where register 0 = event, 1 = mask, 2 = present state and 3 = force. Bits 31..16 and every bit other than 1, 2 and 4 always read 0. Function index 3 reads 0 and ignores writes.
- R2: After reset, every register reads 0, pme_n is 1, inta is 0, and pme_sts and pme_en are 0.
- R3: A pulse on wake_in[f] sets the wake bit of function f (event bit 1) and pme_sts[f] on the next clock.
- R4: Writing 1 to event bit 1 clears the wake bit and pme_sts[f]. Writing 0 there changes nothing.
- R5: A PCI write with pm_sts_clr=1 to function f clears that function's wake bit (event bit 1).
- R6: A PCI write to function f loads pm_en_wr into pme_en[f] and into both mask bit 1 (wake enable) and mask bit 2 (wake master). When a CardBus mask write hits the same function in the same cycle, the PCI value wins for these two bits.
- R7: A CardBus write to the mask register loads bits 1, 2 and 4 and leaves pme_en unchanged.
- R8: Writing to the force register sets the wake bit when bit 1 of the data is 1 and sets the interrupt bit (event bit 4) when bit 4 is 1. Only the addressed function is affected, and the force register reads 0.
- R9: A pulse on irq_detect sets event bit 4 in all three functions.
- R10: Writing 1 to event bit 4 clears the interrupt bit.
- R11: pme_n is 0 exactly when bus_mode is 2'b01 and some function has mask bit 4, mask bit 2, mask bit 1 and event bit 1 all equal to 1.
- R12: inta is 1 exactly when bus_mode is 2'b01 and some function has mask bit 4 and event bit 4 both equal to 1.
- R13: When a set and a clear of the same event bit happen in the same cycle, the bit ends up 1.
- R14: Present-state bit 1 shows the function's wake request (the R11 term) and bit 4 shows its interrupt request (the R12 term). Neither bit depends on bus_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_mode | input | 2 | Bus mode; 2'b01 selects CardBus |
| addr | input | 6 | Register byte address |
| wdata | input | 32 | Register write data |
| we | input | 1 | Register write strobe |
| rdata | output | 32 | Register read data (combinational from addr) |
| pm_we | input | 1 | PCI power-management control/status write strobe |
| pm_fn | input | 2 | Function addressed by the PCI write |
| pm_en_wr | input | 1 | New PME enable value |
| pm_sts_clr | input | 1 | Write-1 value for PME status |
| wake_in | input | 3 | Per-function wake event pulses |
| irq_detect | input | 1 | Shared interrupt-detect pulse |
| pme_n | output | 1 | Active-low power-management event |
| inta | output | 1 | Interrupt request |
| pme_sts | output | 3 | Per-function PME status |
| pme_en | output | 3 | Per-function PME enable |

## Verification
The bench targets several corner cases:
- A set and a clear landing in the same cycle. A design that gives the clear priority loses the event and leaves pme_sts low.
- A PCI enable write colliding with a CardBus mask write. A design with the priority reversed leaves stale wake-enable bits.
- A CardBus mask write followed by a check of pme_en. A design that couples the two would move the PCI enable.
- Force writes and the shared interrupt detect, checked in every function. A design that broadcasts a force, or that does not broadcast the detect, shows the wrong event bits in some function.

Random traffic also switches bus_mode away from CardBus to confirm that both outputs go inactive while the state keeps running, and it writes to the unused function slot, which must never alter state.

// File: rtl/cb_evt_pkg.sv
package cb_evt_pkg;

  localparam int IMPL_W   = 16;
  localparam int BIT_WAKE = 1;
  localparam int BIT_WMST = 2;
  localparam int BIT_IRQ  = 4;

  typedef enum logic [1:0] {
    RG_EVT = 2'd0,
    RG_MSK = 2'd1,
    RG_STS = 2'd2,
    RG_FRC = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wake;
    logic irq;
    logic wake_en;
    logic wake_mst;
    logic irq_mst;
  } fn_state_t;

  // wake request term of one function
  function automatic logic pme_term(fn_state_t s);
    return s.irq_mst & s.wake_mst & s.wake_en & s.wake;
  endfunction

  // interrupt request term of one function
  function automatic logic irq_term(fn_state_t s);
    return s.irq_mst & s.irq;
  endfunction

  // place three flags at their bit positions in the implemented half-word
  function automatic logic [IMPL_W-1:0] place(logic b_wake, logic b_wmst, logic b_irq);
    logic [IMPL_W-1:0] v;
    v = '0;
    v[BIT_WAKE] = b_wake;
    v[BIT_WMST] = b_wmst;
    v[BIT_IRQ]  = b_irq;
    return v;
  endfunction

endpackage

// File: rtl/cb_evt_func.sv
module cb_evt_func
  import cb_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_evt,
  input  logic      wr_msk,
  input  logic      wr_frc,
  input  logic      d_wake,
  input  logic      d_wmst,
  input  logic      d_irq,
  input  logic      pci_we,
  input  logic      pci_en,
  input  logic      pci_clr,
  input  logic      wake_in,
  input  logic      irq_in,
  output fn_state_t st,
  output logic      pme_en_o,
  output logic      pme_req,
  output logic      irq_req
);

  // named internal events
  logic set_wake, clr_wake, set_irq, clr_irq;

  assign set_wake = wake_in | (wr_frc & d_wake);
  assign clr_wake = (wr_evt & d_wake) | (pci_we & pci_clr);
  assign set_irq  = irq_in | (wr_frc & d_irq);
  assign clr_irq  = wr_evt & d_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= '0;
      pme_en_o <= 1'b0;
    end else begin
      st.wake <= set_wake | (st.wake & ~clr_wake);
      st.irq  <= set_irq | (st.irq & ~clr_irq);
      if (pci_we) begin
        pme_en_o    <= pci_en;
        st.wake_en  <= pci_en;
        st.wake_mst <= pci_en;
      end else if (wr_msk) begin
        st.wake_en  <= d_wake;
        st.wake_mst <= d_wmst;
      end
      if (wr_msk) st.irq_mst <= d_irq;
    end
  end

  assign pme_req = pme_term(st);
  assign irq_req = irq_term(st);

  // R3
  wake_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_in |=> st.wake);
  // R13
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_irq && clr_irq) |=> st.irq);
  // R5
  pci_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_we && pci_clr && !set_wake) |=> !st.wake);
  // R6
  pci_en_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pci_we |=> (st.wake_en == $past(pci_en)) && (st.wake_mst == $past(pci_en)));
  // R7
  msk_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msk && !pci_we) |=> $stable(pme_en_o));
  // R9
  irq_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in |=> st.irq);

endmodule

// File: rtl/cb_evt_rdmux.sv
module cb_evt_rdmux
  import cb_evt_pkg::*;
#(
  parameter int NUM_FN = 3,
  parameter int FN_W   = 2,
  parameter int DATA_W = 32
) (
  input  logic                    hit,
  input  logic [FN_W-1:0]         fn_sel,
  input  reg_sel_e                rsel,
  input  fn_state_t [NUM_FN-1:0]  st,
  output logic [DATA_W-1:0]       rdata
);

  logic [IMPL_W-1:0] low;
  fn_state_t s;

  always_comb begin
    s   = '0;
    low = '0;
    for (int i = 0; i < NUM_FN; i++)
      if (fn_sel == FN_W'(i)) s = st[i];
    unique case (rsel)
      RG_EVT: low = place(s.wake, 1'b0, s.irq);
      RG_MSK: low = place(s.wake_en, s.wake_mst, s.irq_mst);
      RG_STS: low = place(pme_term(s), 1'b0, irq_term(s));
      RG_FRC: low = '0;
      default: low = '0;
    endcase
    rdata = hit ? {{(DATA_W-IMPL_W){1'b0}}, low} : '0;
  end

  // R1
  rsvd_zero_chk: assert final (rdata[DATA_W-1:IMPL_W] == '0);

endmodule

// File: rtl/cb_evt_sig.sv
module cb_evt_sig #(
  parameter int NUM_FN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_mode,
  input  logic [NUM_FN-1:0] pme_req,
  input  logic [NUM_FN-1:0] irq_req,
  output logic              pme_n,
  output logic              inta
);

  logic mode_cb;

  assign mode_cb = (bus_mode == 2'b01);
  assign pme_n   = ~(mode_cb & (|pme_req));
  assign inta    = mode_cb & (|irq_req);

  // R11
  pme_mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_cb |-> pme_n);
  // R12
  inta_mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta |-> (bus_mode == 2'b01) && (irq_req != '0));
  // R11
  pme_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pme_n |-> (pme_req != '0));

endmodule

// File: rtl/cb_evt_unit.sv
module cb_evt_unit
  import cb_evt_pkg::*;
#(
  parameter int NUM_FN = 3,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int FN_W  = ADDR_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  input  logic              pm_we,
  input  logic [FN_W-1:0]   pm_fn,
  input  logic              pm_en_wr,
  input  logic              pm_sts_clr,
  input  logic [NUM_FN-1:0] wake_in,
  input  logic              irq_detect,
  output logic              pme_n,
  output logic              inta,
  output logic [NUM_FN-1:0] pme_sts,
  output logic [NUM_FN-1:0] pme_en
);

  logic [FN_W-1:0]       fn_sel;
  reg_sel_e              rsel;
  logic                  hit;
  fn_state_t [NUM_FN-1:0] st;
  logic [NUM_FN-1:0]     pme_req, irq_req;
  logic                  unused_bits;

  assign fn_sel      = addr[ADDR_W-1:4];
  assign rsel        = reg_sel_e'(addr[3:2]);
  assign hit         = (int'(fn_sel) < NUM_FN);
  assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:IMPL_W], wdata[IMPL_W-1:5],
                         wdata[3], wdata[0]};

  for (genvar i = 0; i < NUM_FN; i++) begin : g_fn
    logic sel;
    assign sel = we & hit & (fn_sel == FN_W'(i));
    cb_evt_func u_fn (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_evt   (sel & (rsel == RG_EVT)),
      .wr_msk   (sel & (rsel == RG_MSK)),
      .wr_frc   (sel & (rsel == RG_FRC)),
      .d_wake   (wdata[BIT_WAKE]),
      .d_wmst   (wdata[BIT_WMST]),
      .d_irq    (wdata[BIT_IRQ]),
      .pci_we   (pm_we & (pm_fn == FN_W'(i))),
      .pci_en   (pm_en_wr),
      .pci_clr  (pm_sts_clr),
      .wake_in  (wake_in[i]),
      .irq_in   (irq_detect),
      .st       (st[i]),
      .pme_en_o (pme_en[i]),
      .pme_req  (pme_req[i]),
      .irq_req  (irq_req[i])
    );
    assign pme_sts[i] = st[i].wake;
  end

  cb_evt_rdmux #(.NUM_FN(NUM_FN), .FN_W(FN_W), .DATA_W(DATA_W)) u_rd (
    .hit    (hit),
    .fn_sel (fn_sel),
    .rsel   (rsel),
    .st     (st),
    .rdata  (rdata)
  );

  cb_evt_sig #(.NUM_FN(NUM_FN)) u_sig (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_mode (bus_mode),
    .pme_req  (pme_req),
    .irq_req  (irq_req),
    .pme_n    (pme_n),
    .inta     (inta)
  );

  // R1
  bad_fn_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit && !pm_we && wake_in == '0 && !irq_detect) |=> $stable(st));

endmodule

// File: tb/cb_evt_unit_tb.sv
module cb_evt_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_mode = 2'b01;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic we = 1'b0, pm_we = 1'b0, pm_en_wr = 1'b0, pm_sts_clr = 1'b0, irq_detect = 1'b0;
  logic [1:0] pm_fn = '0;
  logic [NF-1:0] wake_in = '0, pme_sts, pme_en;
  logic pme_n, inta;

  int checks = 0, failures = 0;

  // model state
  logic m_wake[NF], m_irq[NF], m_wen[NF], m_wmst[NF], m_imst[NF], m_pen[NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  cb_evt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .addr(addr), .wdata(wdata),
    .we(we), .rdata(rdata), .pm_we(pm_we), .pm_fn(pm_fn), .pm_en_wr(pm_en_wr),
    .pm_sts_clr(pm_sts_clr), .wake_in(wake_in), .irq_detect(irq_detect),
    .pme_n(pme_n), .inta(inta), .pme_sts(pme_sts), .pme_en(pme_en)
  );

  function automatic logic f_pme(int f);
    return m_imst[f] && m_wmst[f] && m_wen[f] && m_wake[f];
  endfunction

  function automatic logic f_irq(int f);
    return m_imst[f] && m_irq[f];
  endfunction

  function automatic logic [31:0] exp_rd(int f, int r);
    logic [31:0] v = 32'h0;
    if (f >= NF) return v;
    case (r)
      0: begin v[1] = m_wake[f]; v[4] = m_irq[f]; end
      1: begin v[1] = m_wen[f]; v[2] = m_wmst[f]; v[4] = m_imst[f]; end
      2: begin v[1] = f_pme(f); v[4] = f_irq(f); end
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  function automatic logic exp_pme_n();
    logic any = 1'b0;
    for (int f = 0; f < NF; f++) any |= f_pme(f);
    return !(bus_mode == 2'b01 && any);
  endfunction

  function automatic logic exp_inta();
    logic any = 1'b0;
    for (int f = 0; f < NF; f++) any |= f_irq(f);
    return bus_mode == 2'b01 && any;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int f = 0; f < NF; f++) begin
      m_wake[f] = 0; m_irq[f] = 0; m_wen[f] = 0; m_wmst[f] = 0; m_imst[f] = 0; m_pen[f] = 0;
    end
  endtask

  // apply inputs computed from current drive values
  task automatic model_update();
    int f_a = int'(addr[5:4]);
    int r_a = int'(addr[3:2]);
    for (int f = 0; f < NF; f++) begin
      logic sel, sw, cw, si, ci, pw;
      sel = we && (f_a == f);
      pw  = pm_we && (int'(pm_fn) == f);
      sw  = wake_in[f] || (sel && r_a == 3 && wdata[1]);
      cw  = (sel && r_a == 0 && wdata[1]) || (pw && pm_sts_clr);
      si  = irq_detect || (sel && r_a == 3 && wdata[4]);
      ci  = sel && r_a == 0 && wdata[4];
      m_wake[f] = sw || (m_wake[f] && !cw);
      m_irq[f]  = si || (m_irq[f] && !ci);
      if (pw) begin
        m_pen[f] = pm_en_wr; m_wen[f] = pm_en_wr; m_wmst[f] = pm_en_wr;
      end else if (sel && r_a == 1) begin
        m_wen[f] = wdata[1]; m_wmst[f] = wdata[2];
      end
      if (sel && r_a == 1) m_imst[f] = wdata[4];
    end
  endtask

  task automatic check_outs(string tag);
    logic [NF-1:0] es, ee;
    for (int f = 0; f < NF; f++) begin es[f] = m_wake[f]; ee[f] = m_pen[f]; end
    check({tag, " R11 pme_n"}, 32'(pme_n), 32'(exp_pme_n()));
    check({tag, " R12 inta"}, 32'(inta), 32'(exp_inta()));
    check({tag, " R3 pme_sts"}, 32'(pme_sts), 32'(es));
    check({tag, " R6 pme_en"}, 32'(pme_en), 32'(ee));
  endtask

  task automatic step(logic i_we, logic [5:0] a, logic [31:0] d, logic p_we,
                      logic [1:0] p_fn, logic p_en, logic p_clr, logic [NF-1:0] wk,
                      logic irq, string tag);
    we = i_we; addr = a; wdata = d; pm_we = p_we; pm_fn = p_fn;
    pm_en_wr = p_en; pm_sts_clr = p_clr; wake_in = wk; irq_detect = irq;
    @(posedge clk);
    model_update();
    @(negedge clk);
    we = 0; pm_we = 0; pm_sts_clr = 0; wake_in = '0; irq_detect = 0;
    check_outs(tag);
  endtask

  task automatic chk_rd(int f, int r, string tag);
    @(negedge clk);
    addr = 6'(f * 16 + r * 4);
    #1;
    check(tag, rdata, exp_rd(f, r));
  endtask

  function automatic logic [5:0] ad(int f, int r);
    return 6'(f * 16 + r * 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R2 reset state
    check("R2 pme_n", 32'(pme_n), 32'd1);
    check("R2 inta", 32'(inta), 32'd0);
    for (int f = 0; f < 4; f++)
      for (int r = 0; r < 4; r++) chk_rd(f, r, "R2 reset read");

    // R6 PCI enable copies into mask
    step(0, 0, 0, 1, 2'd0, 1, 0, '0, 0, "R6");
    chk_rd(0, 1, "R6 mask read");
    check("R6 mask literal", rdata, 32'h6);
    // R7 CB mask write keeps PCI enable
    step(1, ad(0, 1), 32'h10, 0, 0, 0, 0, '0, 0, "R7");
    check("R7 pme_en kept", 32'(pme_en[0]), 32'd1);
    step(1, ad(0, 1), 32'hFFFF_0016, 0, 0, 0, 0, '0, 0, "R7b");
    chk_rd(0, 1, "R1 reserved mask read");
    // R3 wake pulse, R11 pme, R14 present state
    step(0, 0, 0, 0, 0, 0, 0, 3'b001, 0, "R3");
    check("R11 pme asserted", 32'(pme_n), 32'd0);
    chk_rd(0, 0, "R3 event read");
    chk_rd(0, 2, "R14 state read");
    // R11 mode gating
    bus_mode = 2'b00; #1;
    check("R11 mode off pme_n", 32'(pme_n), 32'd1);
    chk_rd(0, 2, "R14 state mode independent");
    bus_mode = 2'b01;
    // R4 write 0 no effect, write 1 clears
    step(1, ad(0, 0), 32'h0, 0, 0, 0, 0, '0, 0, "R4 zero");
    check("R4 zero keeps", 32'(pme_sts[0]), 32'd1);
    step(1, ad(0, 0), 32'h2, 0, 0, 0, 0, '0, 0, "R4 clr");
    check("R4 cleared", 32'(pme_sts[0]), 32'd0);
    // R8 force wake on fn1, force reads 0, R5 PCI clear
    step(1, ad(1, 3), 32'h2, 0, 0, 0, 0, '0, 0, "R8 force wake");
    check("R8 fn1 wake", 32'(pme_sts), 32'b010);
    chk_rd(1, 3, "R8 force reads zero");
    step(0, 0, 0, 1, 2'd1, 0, 1, '0, 0, "R5");
    check("R5 cleared", 32'(pme_sts[1]), 32'd0);
    // R9 shared detect, R12 inta, R10 clear
    step(0, 0, 0, 0, 0, 0, 0, '0, 1, "R9");
    for (int f = 0; f < NF; f++) chk_rd(f, 0, "R9 irq all fns");
    check("R12 inta", 32'(inta), 32'd1);
    step(1, ad(0, 0), 32'h10, 0, 0, 0, 0, '0, 0, "R10");
    check("R10 inta low", 32'(inta), 32'd0);
    step(1, ad(1, 0), 32'h10, 0, 0, 0, 0, '0, 0, "R10b");
    step(1, ad(2, 0), 32'h10, 0, 0, 0, 0, '0, 0, "R10c");
    step(1, ad(2, 3), 32'h10, 0, 0, 0, 0, '0, 0, "R8 force irq");
    for (int f = 0; f < NF; f++) chk_rd(f, 0, "R8 force irq only fn2");
    // R13 set wins over clear
    step(1, ad(0, 0), 32'h2, 0, 0, 0, 0, 3'b001, 0, "R13");
    check("R13 wake kept", 32'(pme_sts[0]), 32'd1);
    // R6 collision: PCI wins
    step(1, ad(2, 1), 32'h16, 1, 2'd2, 0, 0, '0, 0, "R6 collide");
    chk_rd(2, 1, "R6 collide mask");
    // R1 unused function slot
    step(1, ad(3, 1), 32'hFFFF_FFFF, 0, 0, 0, 0, '0, 0, "R1 fn3");
    chk_rd(3, 1, "R1 fn3 read");

    // random traffic
    for (int n = 0; n < 800; n++) begin
      logic [NF-1:0] wk;
      if (n % 50 == 0) bus_mode = ($urandom % 4 == 0) ? 2'($urandom) : 2'b01;
      for (int f = 0; f < NF; f++) wk[f] = ($urandom % 8 == 0);
      step($urandom % 2 == 0, 6'($urandom) & 6'h3C, $urandom, $urandom % 4 == 0,
           2'($urandom), 1'($urandom), 1'($urandom), wk, $urandom % 8 == 0, "rand");
      chk_rd(int'($urandom % 4), int'($urandom % 4), "R1 R14 rand read");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule